// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves received frame bytes from a MAC byte stream into memory buffers that software describes with a circular list of descriptors. Each descriptor is four 32-bit words (16 bytes). Word 0 holds the command, which contains an operation code, an interrupt select, a branch select, a wait select and a 16-bit request count. Word 1 holds the buffer byte address. Word 2 holds a branch target. Word 3 receives the completion record. The engine reads words 0 to 2. It stores the bytes of one frame into the buffer. When the frame's end marker arrives, it writes word 3 and then moves on to the next descriptor.

A typical ring has sixteen input descriptors. Each requests 2048 bytes, and the buffer for entry i sits at buffer base + 2048*i. A seventeenth descriptor is a no-op that always branches to the list start, so the engine cycles through the ring without help. Software reads the completion record to find filled entries. A set active bit means the entry holds a frame. The frame length is request count minus residual minus 2, because the MAC puts a 2-byte tag ahead of each frame, and the stored bytes include the 4-byte CRC. Software can park the engine in two ways: it can rewrite an upcoming descriptor as a stop, or it can issue the stop command. It resumes the engine with the continue command.

Memory reads return data on the cycle after `memRdEn`. Every write takes effect at the clock edge that samples it.

Top module: `rxdma_ring`

## Requirements
- R1: After `rstN` goes low, or on the cycle after `cmdReset` is sampled high, the engine makes no memory access, holds `rxReady` and `irq` low, and stays so until a start or continue command.
- R2: A start command sampled while the engine is idle loads `listBase`, which must be 16-byte aligned. On the next cycle the engine issues a read of the descriptor word at exactly that address.
- R3: Frame byte n is written to buffer address + n as a single-lane write. Lane k (`memWrEn[k]`, data bits 8k+7:8k) serves byte addresses whose two low bits equal k. No read and write happen in the same cycle.
- R4: At the end of each frame the engine makes exactly one full-word write, at descriptor address + 12. Bits 31:16 hold the status, with bit 15 (active) set. Bits 15:0 hold the residual, which is the request count minus the bytes stored. Words 0 to 2 are never written.
- R5: Bytes beyond the request count are accepted and discarded. Nothing is written past the buffer end, the residual is 0, status bit 8 (overrun) is set, and the next frame goes into the next descriptor.
- R6: After a descriptor, the engine fetches the descriptor 16 bytes further on when the branch select (word 0 bits 19:18) is 2'b00. When it is 2'b11, the engine fetches the descriptor at the word 2 target. This is how the ring wraps.
- R7: An opcode of 6 (no-op, word 0 bits 31:28) causes no buffer write, no completion write and no interrupt. Only its branch select takes effect.
- R8: `irq` is a one-cycle pulse on the cycle after a completion write whose descriptor has interrupt select (bits 21:20) equal to 2'b11. With 2'b00 there is no pulse. The wait select (bits 17:16) is ignored.
- R9: An opcode of 7 (stop) halts fetching. The engine then makes no further reads, and `rxReady` stays low whatever the stream input does.
- R10: A continue command sampled while idle re-reads the descriptor the engine halted on and resumes from it. An opcode of 3 marks an input descriptor.
- R11: A stop command halts the engine before a frame's first byte is taken. If a frame has already begun, the engine halts right after that frame's completion write. Either way, `rxReady` stays low until a continue command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| listBase | input | AddrW | Descriptor list base, taken by a start command |
| cmdStart | input | 1 | Load base and begin fetching (idle only) |
| cmdStop | input | 1 | Request a halt at the next safe point |
| cmdContinue | input | 1 | Re-read the current descriptor and resume (idle only) |
| cmdReset | input | 1 | Clear the channel to idle |
| rxValid | input | 1 | Stream byte valid |
| rxByte | input | 8 | Stream byte |
| rxLast | input | 1 | Marks the last byte of a frame |
| rxReady | output | 1 | Engine takes a byte this cycle when rxValid is high |
| memRdEn | output | 1 | Word read request; data returns next cycle |
| memWrEn | output | 4 | Byte-lane write enables |
| memAddr | output | AddrW | Byte address for read or write |
| memWrData | output | 32 | Write data |
| memRdData | input | 32 | Read data for the previous cycle's request |
| irq | output | 1 | Per-frame completion pulse |

## Verification
A corrupted descriptor pointer or a byte counter that is off by one shows up at the first completion write that follows. The write lands at the wrong descriptor slot, or it carries a residual that disagrees with the frame length, so the scoreboard sees the error within one frame. A control state that misses a stop or a halt shows within a cycle or two: `rxReady` or `memRdEn` rises while the engine is meant to be parked. A miscounted truncation shows as a write into the guard word of the next buffer, or as a missing overrun bit.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;

  // Operation codes in command word bits 31:28
  localparam logic [3:0] OpInLast = 4'd3;
  localparam logic [3:0] OpNop    = 4'd6;
  localparam logic [3:0] OpStop   = 4'd7;

  // Select field encodings (interrupt / branch)
  localparam logic [1:0] SelNever  = 2'b00;
  localparam logic [1:0] SelAlways = 2'b11;

  // Field positions in command word
  localparam int OpLsb  = 28;
  localparam int IntLsb = 20;
  localparam int BrLsb  = 18;
  localparam int CntW   = 16;

  // Completion status bits
  localparam logic [15:0] StActive  = 16'h8000;
  localparam logic [15:0] StOverrun = 16'h0100;

  // Descriptor word indexes
  localparam logic [1:0] WordCmd = 2'd0;
  localparam logic [1:0] WordBuf = 2'd1;
  localparam logic [1:0] WordBr  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_CAP, S_DEC, S_RECV, S_WB
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       chanClear;
    logic       loadBase;
    logic       issueRd;
    logic [1:0] rdIdx;
    logic       capValid;
    logic [1:0] capIdx;
    logic       clearFrame;
    logic       storeByte;
    logic       dropByte;
    logic       writeBack;
    logic       advance;
  } dpCtrl_t;

endpackage

// File: rtl/rxdma_datapath.sv
`timescale 1ns/1ps
module rxdma_datapath
  import rxdma_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int DescBytes = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [AddrW-1:0] listBase,
  input  logic [7:0]       rxByte,
  input  logic [31:0]      memRdData,
  output logic [AddrW-1:0] memAddr,
  output logic [31:0]      memWrData,
  output logic [3:0]       memWrEn,
  output logic             memRdEn,
  output logic [3:0]       opCode,
  output logic             intAlways,
  output logic             bufFull
);

  localparam int Lanes    = 4;
  localparam int WbOffset = DescBytes - Lanes;

  logic [AddrW-1:0] descPtr;
  logic [AddrW-1:0] bufAddr;
  logic [AddrW-1:0] brTarget;
  logic [3:0]       opReg;
  logic [1:0]       intSel;
  logic [1:0]       brSel;
  logic [CntW-1:0]  reqCount;
  logic [CntW-1:0]  byteCnt;
  logic             overrun;

  logic [AddrW-1:0] nextPtr;
  logic [AddrW-1:0] dataAddr;
  logic [31:0]      wbWord;
  logic [15:0]      statusVal;

  assign nextPtr   = (brSel == SelAlways) ? brTarget : descPtr + AddrW'(DescBytes);
  assign dataAddr  = bufAddr + AddrW'(byteCnt);
  assign statusVal = StActive | (overrun ? StOverrun : 16'h0000);
  assign wbWord    = {statusVal, reqCount - byteCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr  <= '0;
      bufAddr  <= '0;
      brTarget <= '0;
      opReg    <= '0;
      intSel   <= '0;
      brSel    <= '0;
      reqCount <= '0;
      byteCnt  <= '0;
      overrun  <= 1'b0;
    end else if (ctl.chanClear) begin
      descPtr  <= '0;
      opReg    <= '0;
      intSel   <= '0;
      brSel    <= '0;
      reqCount <= '0;
      byteCnt  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (ctl.loadBase) descPtr <= listBase;
      if (ctl.advance)  descPtr <= nextPtr;
      if (ctl.capValid) begin
        case (ctl.capIdx)
          WordCmd: begin
            opReg    <= memRdData[OpLsb +: 4];
            intSel   <= memRdData[IntLsb +: 2];
            brSel    <= memRdData[BrLsb +: 2];
            reqCount <= memRdData[CntW-1:0];
          end
          WordBuf: bufAddr  <= memRdData[AddrW-1:0];
          WordBr:  brTarget <= memRdData[AddrW-1:0];
          default: ;
        endcase
      end
      if (ctl.clearFrame) begin
        byteCnt <= '0;
        overrun <= 1'b0;
      end
      if (ctl.storeByte) byteCnt <= byteCnt + 1'b1;
      if (ctl.dropByte)  overrun <= 1'b1;
    end
  end

  always_comb begin
    if (ctl.issueRd)        memAddr = descPtr + AddrW'({ctl.rdIdx, 2'b00});
    else if (ctl.writeBack) memAddr = descPtr + AddrW'(WbOffset);
    else                    memAddr = dataAddr;
  end

  for (genvar l = 0; l < Lanes; l++) begin : g_lane
    assign memWrData[8*l +: 8] = ctl.writeBack ? wbWord[8*l +: 8] : rxByte;
    assign memWrEn[l] = ctl.writeBack | (ctl.storeByte & (dataAddr[1:0] == 2'(l)));
  end

  assign memRdEn   = ctl.issueRd;
  assign opCode    = opReg;
  assign intAlways = (intSel == SelAlways);
  assign bufFull   = (byteCnt == reqCount);

endmodule

// File: rtl/rxdma_control.sv
`timescale 1ns/1ps
module rxdma_control
  import rxdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdContinue,
  input  logic       cmdReset,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic [3:0] opCode,
  input  logic       intAlways,
  input  logic       bufFull,
  output logic       rxReady,
  output logic       irq,
  output dpCtrl_t    ctl
);

  rxState_t state, nxt;
  logic     stopReq;
  logic     begun;

  always_comb begin
    ctl     = '0;
    rxReady = 1'b0;
    nxt     = state;
    case (state)
      S_IDLE: begin
        if (cmdStart) begin
          ctl.loadBase = 1'b1;
          nxt          = S_RD0;
        end else if (cmdContinue) begin
          nxt = S_RD0;
        end
      end
      S_RD0: begin
        ctl.issueRd = 1'b1;
        ctl.rdIdx   = WordCmd;
        nxt         = S_RD1;
      end
      S_RD1: begin
        ctl.issueRd  = 1'b1;
        ctl.rdIdx    = WordBuf;
        ctl.capValid = 1'b1;
        ctl.capIdx   = WordCmd;
        nxt          = S_RD2;
      end
      S_RD2: begin
        ctl.issueRd  = 1'b1;
        ctl.rdIdx    = WordBr;
        ctl.capValid = 1'b1;
        ctl.capIdx   = WordBuf;
        nxt          = S_CAP;
      end
      S_CAP: begin
        ctl.capValid = 1'b1;
        ctl.capIdx   = WordBr;
        nxt          = S_DEC;
      end
      S_DEC: begin
        if (opCode == OpInLast) begin
          ctl.clearFrame = 1'b1;
          nxt            = stopReq ? S_IDLE : S_RECV;
        end else if (opCode == OpNop) begin
          ctl.advance = 1'b1;
          nxt         = stopReq ? S_IDLE : S_RD0;
        end else begin
          nxt = S_IDLE;
        end
      end
      S_RECV: begin
        if (stopReq && !begun) begin
          nxt = S_IDLE;
        end else begin
          rxReady = 1'b1;
          if (rxValid) begin
            if (bufFull) ctl.dropByte  = 1'b1;
            else         ctl.storeByte = 1'b1;
            if (rxLast)  nxt = S_WB;
          end
        end
      end
      S_WB: begin
        ctl.writeBack = 1'b1;
        ctl.advance   = 1'b1;
        nxt           = stopReq ? S_IDLE : S_RD0;
      end
      default: nxt = S_IDLE;
    endcase
    if (cmdReset) begin
      ctl           = '0;
      ctl.chanClear = 1'b1;
      rxReady       = 1'b0;
      nxt           = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      irq     <= 1'b0;
      stopReq <= 1'b0;
      begun   <= 1'b0;
    end else begin
      state <= nxt;
      irq   <= (state == S_WB) && intAlways && !cmdReset;
      if (cmdReset || nxt == S_IDLE) stopReq <= 1'b0;
      else if (cmdStop)              stopReq <= 1'b1;
      if (cmdReset || state == S_DEC) begun <= 1'b0;
      else if (rxReady && rxValid)    begun <= 1'b1;
    end
  end

endmodule

// File: rtl/rxdma_ring.sv
`timescale 1ns/1ps
module rxdma_ring
  import rxdma_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int DescBytes = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] listBase,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             cmdContinue,
  input  logic             cmdReset,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxLast,
  output logic             rxReady,
  output logic             memRdEn,
  output logic [3:0]       memWrEn,
  output logic [AddrW-1:0] memAddr,
  output logic [31:0]      memWrData,
  input  logic [31:0]      memRdData,
  output logic             irq
);

  dpCtrl_t    ctl;
  logic [3:0] opCode;
  logic       intAlways;
  logic       bufFull;

  rxdma_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .cmdStop    (cmdStop),
    .cmdContinue(cmdContinue),
    .cmdReset   (cmdReset),
    .rxValid    (rxValid),
    .rxLast     (rxLast),
    .opCode     (opCode),
    .intAlways  (intAlways),
    .bufFull    (bufFull),
    .rxReady    (rxReady),
    .irq        (irq),
    .ctl        (ctl)
  );

  rxdma_datapath #(
    .AddrW    (AddrW),
    .DescBytes(DescBytes)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .listBase (listBase),
    .rxByte   (rxByte),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memWrEn  (memWrEn),
    .memRdEn  (memRdEn),
    .opCode   (opCode),
    .intAlways(intAlways),
    .bufFull  (bufFull)
  );

endmodule

// File: rtl/rxdma_ring_checker.sv
`timescale 1ns/1ps
module rxdma_ring_checker #(
  parameter int DescBytes = 16,
  parameter int OffW      = $clog2(DescBytes)
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdReset,
  input logic            rxReady,
  input logic            memRdEn,
  input logic [3:0]      memWrEn,
  input logic [OffW-1:0] addrLow,
  input logic            irq
);

  // R8: interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R8: interrupt follows a completion write by one cycle
  p_irq_after_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(memWrEn == 4'hF));

  // R4: completion write lands in the last word of a descriptor
  p_wb_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn == 4'hF) |-> (addrLow == OffW'(DescBytes - 4)));

  // R3: data writes use exactly the lane of their address
  p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn != 4'h0 && memWrEn != 4'hF) |->
      ($countones(memWrEn) == 1 && memWrEn[addrLow[1:0]]));

  // R3: no read and write in the same cycle
  p_no_rdwr_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn != 4'h0));

  // R1: quiet after a reset command
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdReset) |-> (!rxReady && !memRdEn && memWrEn == 4'h0 && !irq));

  // R9: no descriptor fetch while taking stream bytes
  p_ready_no_fetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> !memRdEn);

endmodule

bind rxdma_ring rxdma_ring_checker #(.DescBytes(DescBytes)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .cmdReset(cmdReset),
  .rxReady (rxReady),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn),
  .addrLow (memAddr[$clog2(DescBytes)-1:0]),
  .irq     (irq)
);

// File: tb/rxdma_ring_test.sv
`timescale 1ns/1ps
module rxdma_ring_test;

  localparam logic [31:0] RingBase = 32'h0000_0100;
  localparam logic [31:0] BufBase  = 32'h0000_1000;
  localparam int          BufLen   = 2048;
  localparam logic [3:0]  OpIn = 4'd3, OpNp = 4'd6, OpSt = 4'd7;
  localparam logic [1:0]  Nev = 2'b00, Alw = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] listBase = '0;
  logic        cmdStart = 0, cmdStop = 0, cmdContinue = 0, cmdReset = 0;
  logic        rxValid = 0, rxLast = 0;
  logic [7:0]  rxByte = '0;
  logic        rxReady, memRdEn, irq;
  logic [3:0]  memWrEn;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;

  always #4 clk = ~clk;

  rxdma_ring uut (
    .clk(clk), .rstN(rstN), .listBase(listBase), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdContinue(cmdContinue), .cmdReset(cmdReset),
    .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast), .rxReady(rxReady),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .irq(irq)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] rdWord(logic [31:0] a);
    int unsigned k = int'(a >> 2);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  function automatic logic [7:0] getByte(logic [31:0] a);
    logic [31:0] w = rdWord(a);
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic putWord(logic [31:0] a, logic [31:0] v);
    mem[int'(a >> 2)] = v;
  endtask

  always @(posedge clk) begin
    if (memRdEn) memRdData <= rdWord(memAddr);
    if (memWrEn != 4'h0) begin
      logic [31:0] w;
      w = rdWord(memAddr);
      for (int l = 0; l < 4; l++)
        if (memWrEn[l]) w[8*l +: 8] = memWrData[8*l +: 8];
      mem[int'(memAddr >> 2)] = w;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int lastWbCyc = -10;
  int irqSeen = 0;
  int expIrq = 0;
  bit prevIrq = 0;
  bit finished = 0;
  logic [63:0] expQ[$];
  logic [31:0] shadowCmd [17];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(logic [3:0] op, logic [1:0] i, logic [1:0] b, logic [15:0] n);
    return {op, 6'b0, i, b, 2'b00, n};
  endfunction

  function automatic logic [31:0] descAddr(int i);
    return RingBase + 32'(16 * i);
  endfunction

  function automatic logic [31:0] bufAddrOf(int i);
    return BufBase + 32'(BufLen * i);
  endfunction

  task automatic setDesc(int i, logic [3:0] op, logic [1:0] intS);
    shadowCmd[i] = mkCmd(op, intS, Nev, 16'(BufLen));
    putWord(descAddr(i),      shadowCmd[i]);
    putWord(descAddr(i) + 4,  bufAddrOf(i));
    putWord(descAddr(i) + 8,  RingBase);
    putWord(descAddr(i) + 12, 32'h0);
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed * 31 + k * 7 + (k >> 8));
  endfunction

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn == 4'hF) begin
        lastWbCyc = cyc;
        if (expQ.size() == 0) begin
          chk(0, "R7", "unexpected completion write", {memAddr, memWrData}, 0);
        end else begin
          logic [63:0] e;
          e = expQ.pop_front();
          chk({memAddr, memWrData} == e, "R4", "completion addr/word",
              {memAddr, memWrData}, e);
        end
      end
      if (irq) begin
        irqSeen++;
        chk(cyc == lastWbCyc + 1 && !prevIrq, "R8", "irq one cycle after write",
            cyc - lastWbCyc, 1);
      end
      prevIrq = irq;
    end
  end

  // ---------------- driver ----------------
  task automatic sendFrame(int idx, int len, int seed, bit intOn, int stopAt);
    int stored = (len < BufLen) ? len : BufLen;
    int resid = BufLen - stored;
    logic [15:0] st = 16'h8000 | ((len > BufLen) ? 16'h0100 : 16'h0000);
    int k = 0;
    int t = 0;
    bit ok = 1;
    int badAt = -1;
    expQ.push_back({descAddr(idx) + 32'd12, st, 16'(resid)});
    if (intOn) expIrq++;
    while (k < len && t < 20000) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxByte  = pat(seed, k);
      rxLast  = (k == len - 1);
      cmdStop = (k == stopAt);
      if (rxReady) k++;
      t++;
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxLast  = 1'b0;
    cmdStop = 1'b0;
    chk(k == len, "R3", "all frame bytes accepted", k, len);
    t = 0;
    while (expQ.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R4", "completion write seen", expQ.size(), 0);
    chk(irqSeen == expIrq, "R8", "irq count", irqSeen, expIrq);
    for (int n = 0; n < stored; n++)
      if (ok && getByte(bufAddrOf(idx) + 32'(n)) != pat(seed, n)) begin
        ok = 0;
        badAt = n;
      end
    chk(ok, "R3", "buffer contents (first bad index)", badAt, -1);
    chk(rdWord(descAddr(idx)) == shadowCmd[idx] &&
        rdWord(descAddr(idx) + 4) == bufAddrOf(idx) &&
        rdWord(descAddr(idx) + 8) == RingBase,
        "R4", "descriptor words 0-2 kept", rdWord(descAddr(idx)), shadowCmd[idx]);
  endtask

  task automatic pulseContinue();
    @(negedge clk) cmdContinue = 1'b1;
    @(negedge clk) cmdContinue = 1'b0;
  endtask

  task automatic checkParked(string tag, int n);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxByte  = 8'hEE;
      if (rxReady || memRdEn || memWrEn != 4'h0) ok = 0;
    end
    @(negedge clk) rxValid = 1'b0;
    chk(ok, tag, "engine parked (ready/read/write seen)", !ok, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < 16; i++) setDesc(i, OpIn, (i == 5) ? Nev : Alw);
    shadowCmd[16] = mkCmd(OpNp, Nev, Alw, 16'd0);
    putWord(descAddr(16),     shadowCmd[16]);
    putWord(descAddr(16) + 4, 32'h0);
    putWord(descAddr(16) + 8, RingBase);
    putWord(bufAddrOf(4), 32'hA5A5_A5A5);

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!rxReady && !irq && !memRdEn && memWrEn == 4'h0, "R1", "quiet after reset",
        {rxReady, irq, memRdEn, memWrEn}, 0);

    // R2: start fetches at the base
    listBase = RingBase;
    cmdStart = 1'b1;
    @(negedge clk) cmdStart = 1'b0;
    chk(memRdEn && memAddr == RingBase, "R2", "first fetch address", memAddr, RingBase);

    sendFrame(0, 64, 1, 1, -1);
    sendFrame(1, 1, 2, 1, -1);
    sendFrame(2, 2048, 3, 1, -1);     // exact fill: residual 0, no overrun
    sendFrame(3, 2051, 4, 1, -1);     // R5: truncated, overrun bit
    chk(rdWord(bufAddrOf(4)) == 32'hA5A5_A5A5, "R5", "no write past buffer end",
        rdWord(bufAddrOf(4)), 32'hA5A5_A5A5);
    sendFrame(4, 100, 5, 1, -1);      // R5: next frame in next descriptor
    sendFrame(5, 30, 6, 0, -1);       // R8: interrupt select never
    for (int i = 6; i < 16; i++) sendFrame(i, 8 + i, 10 + i, 1, -1);
    // R6/R7: no-op branches back, frame lands in entry 0
    sendFrame(0, 20, 40, 1, -1);

    // R9: stop descriptor at entry 2
    setDesc(2, OpSt, Alw);
    sendFrame(1, 12, 41, 1, -1);
    repeat (8) @(negedge clk);
    checkParked("R9", 30);

    // R10: restore and continue from the halted descriptor
    setDesc(2, OpIn, Alw);
    pulseContinue();
    sendFrame(2, 16, 42, 1, -1);

    // R11: stop command before first byte
    repeat (10) @(negedge clk);
    @(negedge clk) cmdStop = 1'b1;
    @(negedge clk) cmdStop = 1'b0;
    checkParked("R11", 20);
    pulseContinue();
    sendFrame(3, 40, 43, 1, -1);      // R10 resume same descriptor

    // R11: stop command mid-frame, frame completes then halts
    sendFrame(4, 50, 44, 1, 10);
    checkParked("R11", 20);
    pulseContinue();
    sendFrame(5, 25, 45, 0, -1);

    // R1: reset command clears the channel
    repeat (10) @(negedge clk);
    @(negedge clk) cmdReset = 1'b1;
    @(negedge clk) cmdReset = 1'b0;
    chk(!rxReady && !memRdEn && !irq, "R1", "quiet after reset command",
        {rxReady, memRdEn, irq}, 0);
    checkParked("R1", 10);

    // R2: restart from base
    @(negedge clk) cmdStart = 1'b1;
    @(negedge clk) cmdStart = 1'b0;
    chk(memRdEn && memAddr == RingBase, "R2", "fetch address after restart", memAddr, RingBase);
    sendFrame(0, 33, 46, 1, -1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule